// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. A free-running up/down time base sweeps each switching period in two equal halves. Each phase compares its duty value against that sweep, so the high-side pulse sits in the middle of the period and the low side fills the rest. Dead time separates the two sides of a leg. Pulses that are too narrow are removed. Every output can be masked, chopped by a fast carrier, or inverted to suit the gate driver. An active-low trip input forces every output to its inactive level at once.

Software writes through a small register port into shadow registers. The running copies update only at boundaries. In single update mode that is the period start. In double update mode the duties also reload at the mid-period point, so each half of the period can carry its own duty. A sync pulse marks the start of every period, so other logic, such as a converter trigger, can lock to the switching pattern.

Top module: `tri_phase_pwm`

## Requirements
- R1: While `rst_n` is low with `act_high`=1, all six gate pins, `sync_o` and `trip_o` read 0. After reset the half-period is 64, every duty, dead time and minimum pulse is 0, all outputs are enabled, and chopping and double update are off.
- R2: The half-period H is written at address 0; values below 2 act as 2. A period lasts 2H clocks. For a phase duty D (addresses 1, 2, 3 for phases A, B, C), the high side is demanded for 2D clocks centred in the period and the low side for the other 2(H-D). A duty above H behaves exactly as D=H, which means fully on.
- R3: The dead time DT is in bits [9:0] of address 4. After every change of a phase's demand, both sides of that leg stay inactive for 2·DT clocks. A high side and low side of the same leg are never active together.
- R4: The minimum pulse MP is in bits [9:0] of address 5. It is applied to the duty in force for each half-period. If that duty is below MP, the high side is off for the whole half. If H minus that duty is below MP, the high side is on for the whole half.
- R5: In single update mode (address 6 bit 0 = 0), writes to addresses 0–5 take effect only at the next period start. A duty written during a period leaves the rest of that period unchanged.
- R6: In double update mode (address 6 bit 0 = 1), duty writes also take effect at the mid-period point. The second half of the same period then uses the new duty.
- R7: Address 7 bits [7:0] hold a sync width code W. `sync_o` rises on the first clock of every period and stays high for W+1 clocks.
- R8: Address 6 bits [7:2] enable the outputs in the order AH, AL, BH, BL, CH, CL (gate_o bits 0 to 5). A cleared enable holds that output inactive, and the other outputs are unaffected.
- R9: `act_high`=1 makes an active gate read 1; `act_high`=0 inverts all six pins.
- R10: Address 6 bit 1 enables chopping. All six gates are then ANDed with a carrier that toggles every C+1 clocks, where C is in bits [15:8] of address 7.
- R11: `trip_n` low drives all six pins to the inactive level without waiting for a clock edge, and sets `trip_o`. The trip stays latched after `trip_n` returns high. It is cleared only by a write to address 6 with bit 15 set while `trip_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| act_high | input | 1 | Gate polarity: 1 active high, 0 active low |
| trip_n | input | 1 | Asynchronous active-low shutdown |
| gate_o | output | 6 | Gate pins AH, AL, BH, BL, CH, CL (bit 0 to 5) |
| sync_o | output | 1 | Period start pulse |
| trip_o | output | 1 | Latched trip flag |

## Verification
A wrong time-base count or a missed update strobe shows up within one period. It changes the number of clocks each gate is active between two sync rises, so the bench counts active clocks per pin over whole periods and compares those counts against the timing law. A dead-time or pulse-trim fault changes those counts by a known multiple of the programmed values. A shadow transfer at the wrong boundary moves a pulse into the wrong half of the period in which the write was made. Trip handling is observed within the same clock as the trip input falls.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NPH  = 3;
  localparam int NOUT = 2 * NPH;

  typedef enum logic [2:0] {
    RA_HALF   = 3'd0,
    RA_DUTY_A = 3'd1,
    RA_DUTY_B = 3'd2,
    RA_DUTY_C = 3'd3,
    RA_DEAD   = 3'd4,
    RA_MINP   = 3'd5,
    RA_CTRL   = 3'd6,
    RA_AUX    = 3'd7
  } reg_addr_e;

  localparam int CTL_DBL    = 0;
  localparam int CTL_CHOP   = 1;
  localparam int CTL_EN_LSB = 2;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile import pwm_pkg::*; #(
  parameter int CW = 16,
  parameter int DTW = 10,
  parameter int MPW = 10,
  parameter int SWW = 8,
  parameter int CDW = 8,
  parameter int unsigned DEF_HALF = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     load_all,
  input  logic                     load_duty,
  output logic [CW-1:0]            h_act,
  output logic [NPH-1:0][CW-1:0]   duty_act,
  output logic [DTW-1:0]           dt_act,
  output logic [MPW-1:0]           mp_act,
  output logic                     dbl_mode,
  output logic                     chop_en,
  output logic [NOUT-1:0]          en_mask,
  output logic [SWW-1:0]           sync_w,
  output logic [CDW-1:0]           chop_div,
  output logic                     trip_clr
);
  localparam logic [CW-1:0] HALF_RST = CW'(DEF_HALF);
  localparam int CLR_BIT = CW - 1;

  reg_addr_e                addr_e;
  logic [CW-1:0]            h_sh;
  logic [NPH-1:0][CW-1:0]   duty_sh;
  logic [DTW-1:0]           dt_sh;
  logic [MPW-1:0]           mp_sh;

  assign addr_e   = reg_addr_e'(wr_addr);
  assign trip_clr = wr_en && (addr_e == RA_CTRL) && wr_data[CLR_BIT];

  // shadow side and immediate controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_sh     <= HALF_RST;
      duty_sh  <= '0;
      dt_sh    <= '0;
      mp_sh    <= '0;
      dbl_mode <= 1'b0;
      chop_en  <= 1'b0;
      en_mask  <= '1;
      sync_w   <= '0;
      chop_div <= '0;
    end else if (wr_en) begin
      case (addr_e)
        RA_HALF:   h_sh       <= wr_data;
        RA_DUTY_A: duty_sh[0] <= wr_data;
        RA_DUTY_B: duty_sh[1] <= wr_data;
        RA_DUTY_C: duty_sh[2] <= wr_data;
        RA_DEAD:   dt_sh      <= wr_data[DTW-1:0];
        RA_MINP:   mp_sh      <= wr_data[MPW-1:0];
        RA_CTRL: begin
          dbl_mode <= wr_data[CTL_DBL];
          chop_en  <= wr_data[CTL_CHOP];
          en_mask  <= wr_data[CTL_EN_LSB +: NOUT];
        end
        RA_AUX: begin
          sync_w   <= wr_data[SWW-1:0];
          chop_div <= wr_data[CW-1 -: CDW];
        end
      endcase
    end
  end

  // running copies follow the boundary strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_act    <= HALF_RST;
      duty_act <= '0;
      dt_act   <= '0;
      mp_act   <= '0;
    end else if (load_all) begin
      h_act    <= h_sh;
      duty_act <= duty_sh;
      dt_act   <= dt_sh;
      mp_act   <= mp_sh;
    end else if (load_duty) begin
      duty_act <= duty_sh;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16,
  parameter int SWW = 8,
  parameter int CDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  h_act,
  input  logic           dbl_mode,
  input  logic [SWW-1:0] sync_w,
  input  logic [CDW-1:0] chop_div,
  output logic [CW-1:0]  k,
  output logic           half,
  output logic [CW-1:0]  h_eff,
  output logic           load_all,
  output logic           load_duty,
  output logic           sync_o,
  output logic           carrier
);
  function automatic logic [CW-1:0] eff_half(input logic [CW-1:0] h);
    return (h < CW'(2)) ? CW'(2) : h;
  endfunction

  logic [CW-1:0]  k_q;
  logic           half_q;
  logic [SWW-1:0] scnt_q;
  logic           sync_q;
  logic [CDW-1:0] cc_q;
  logic           car_q;
  logic           at_half_end;
  logic           period_start;

  assign h_eff        = eff_half(h_act);
  assign at_half_end  = (k_q == h_eff - CW'(1));
  assign load_all     = at_half_end & half_q;
  assign load_duty    = at_half_end & ~half_q & dbl_mode;
  assign period_start = (k_q == '0) && !half_q;
  assign k            = k_q;
  assign half         = half_q;
  assign sync_o       = sync_q;
  assign carrier      = car_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= '0;
      half_q <= 1'b0;
    end else if (at_half_end) begin
      k_q    <= '0;
      half_q <= ~half_q;
    end else begin
      k_q <= k_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      scnt_q <= '0;
    end else if (load_all) begin
      sync_q <= 1'b1;
      scnt_q <= sync_w;
    end else if (sync_q) begin
      if (scnt_q == '0) sync_q <= 1'b0;
      else              scnt_q <= scnt_q - SWW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q  <= '0;
      car_q <= 1'b1;
    end else if (cc_q >= chop_div) begin
      cc_q  <= '0;
      car_q <= ~car_q;
    end else begin
      cc_q <= cc_q + CDW'(1);
    end
  end

  AST_K_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    k_q < h_eff); // R2
  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> period_start); // R7
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase #(
  parameter int CW = 16,
  parameter int DTW = 10,
  parameter int MPW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  k,
  input  logic           half,
  input  logic [CW-1:0]  h_eff,
  input  logic [CW-1:0]  duty,
  input  logic [MPW-1:0] mp,
  input  logic [DTW-1:0] dt,
  output logic           gate_h,
  output logic           gate_l
);
  function automatic logic [CW-1:0] sat_duty(input logic [CW-1:0] d, input logic [CW-1:0] h);
    return (d > h) ? h : d;
  endfunction

  function automatic logic [CW-1:0] trim_duty(input logic [CW-1:0] d, input logic [CW-1:0] h,
                                              input logic [MPW-1:0] m);
    logic [CW-1:0] mw;
    mw = CW'(m);
    if (d < mw)       return '0;
    if ((h - d) < mw) return h;
    return d;
  endfunction

  function automatic logic side_demand(input logic hf, input logic [CW-1:0] kk,
                                       input logic [CW-1:0] d, input logic [CW-1:0] h);
    return hf ? (kk < d) : (kk >= h - d);
  endfunction

  logic [CW-1:0] duty_eff;
  logic          demand_w;
  logic          raw_q;
  logic [DTW:0]  dtc_q;
  logic [DTW:0]  dt2;
  logic          dead_idle;

  assign duty_eff  = trim_duty(sat_duty(duty, h_eff), h_eff, mp);
  assign demand_w  = side_demand(half, k, duty_eff, h_eff);
  assign dt2       = {dt, 1'b0};
  assign dead_idle = (dtc_q == '0);
  assign gate_h    = raw_q & dead_idle;
  assign gate_l    = ~raw_q & dead_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      dtc_q <= '0;
    end else begin
      raw_q <= demand_w;
      if (demand_w != raw_q)  dtc_q <= dt2;
      else if (!dead_idle)    dtc_q <= dtc_q - (DTW+1)'(1);
    end
  end

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((demand_w != raw_q) && (dt != '0)) |=> (!gate_h && !gate_l)); // R3
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage import pwm_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trip_n,
  input  logic            trip_clr,
  input  logic [NOUT-1:0] gates,
  input  logic [NOUT-1:0] en_mask,
  input  logic            chop_en,
  input  logic            carrier,
  input  logic            act_high,
  output logic [NOUT-1:0] gate_o,
  output logic            trip_o
);
  logic [NOUT-1:0] out_q;
  logic [NOUT-1:0] chop_mask;
  logic [NOUT-1:0] live;
  logic            trip_q;
  logic            shut;

  assign chop_mask = chop_en ? {NOUT{carrier}} : {NOUT{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= gates & en_mask & chop_mask;
  end

  always_ff @(posedge clk or negedge rst_n or negedge trip_n) begin
    if (!rst_n)       trip_q <= 1'b0;
    else if (!trip_n) trip_q <= 1'b1;
    else if (trip_clr) trip_q <= 1'b0;
  end

  assign shut   = trip_q | ~trip_n;
  assign live   = out_q & ~{NOUT{shut}};
  assign gate_o = act_high ? live : ~live;
  assign trip_o = trip_q;

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_q[2*p] && out_q[2*p+1])); // R3
  end

  AST_TRIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> (gate_o == {NOUT{~act_high}})); // R11
  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && !trip_clr) |=> trip_o); // R11
endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm import pwm_pkg::*; #(
  parameter int CW = 16,
  parameter int DTW = 10,
  parameter int MPW = 10,
  parameter int SWW = 8,
  parameter int CDW = 8,
  parameter int unsigned DEF_HALF = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic            act_high,
  input  logic            trip_n,
  output logic [NOUT-1:0] gate_o,
  output logic            sync_o,
  output logic            trip_o
);
  logic [CW-1:0]          h_act;
  logic [NPH-1:0][CW-1:0] duty_act;
  logic [DTW-1:0]         dt_act;
  logic [MPW-1:0]         mp_act;
  logic                   dbl_mode;
  logic                   chop_en;
  logic [NOUT-1:0]        en_mask;
  logic [SWW-1:0]         sync_w;
  logic [CDW-1:0]         chop_div;
  logic                   trip_clr;
  logic [CW-1:0]          k;
  logic                   half;
  logic [CW-1:0]          h_eff;
  logic                   load_all;
  logic                   load_duty;
  logic                   carrier;
  logic [NOUT-1:0]        gates;

  pwm_regfile #(.CW(CW), .DTW(DTW), .MPW(MPW), .SWW(SWW), .CDW(CDW), .DEF_HALF(DEF_HALF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_all(load_all), .load_duty(load_duty),
    .h_act(h_act), .duty_act(duty_act), .dt_act(dt_act), .mp_act(mp_act),
    .dbl_mode(dbl_mode), .chop_en(chop_en), .en_mask(en_mask),
    .sync_w(sync_w), .chop_div(chop_div), .trip_clr(trip_clr)
  );

  pwm_timebase #(.CW(CW), .SWW(SWW), .CDW(CDW)) u_tb (
    .clk(clk), .rst_n(rst_n), .h_act(h_act), .dbl_mode(dbl_mode),
    .sync_w(sync_w), .chop_div(chop_div), .k(k), .half(half), .h_eff(h_eff),
    .load_all(load_all), .load_duty(load_duty), .sync_o(sync_o), .carrier(carrier)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pwm_phase #(.CW(CW), .DTW(DTW), .MPW(MPW)) u_ph (
      .clk(clk), .rst_n(rst_n), .k(k), .half(half), .h_eff(h_eff),
      .duty(duty_act[p]), .mp(mp_act), .dt(dt_act),
      .gate_h(gates[2*p]), .gate_l(gates[2*p+1])
    );
  end

  pwm_outstage u_out (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .trip_clr(trip_clr),
    .gates(gates), .en_mask(en_mask), .chop_en(chop_en), .carrier(carrier),
    .act_high(act_high), .gate_o(gate_o), .trip_o(trip_o)
  );

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_all |=> ($stable(h_act) && $stable(dt_act) && $stable(mp_act))); // R5
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_all && !load_duty) |=> $stable(duty_act)); // R6
endmodule

// File: tb/sim_tri_phase_pwm.sv
`timescale 1ns/100ps
module sim_tri_phase_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        act_high = 1'b1;
  logic        trip_n = 1'b1;
  wire  [5:0]  gate_o;
  wire         sync_o;
  wire         trip_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [6:0][15:0] v;
    logic [6:0]       m;
    logic [7:0]       r;
  } item_t;

  item_t q[$];
  bit    armed = 1'b0;
  int    cnt[7];
  logic  sync_prev = 1'b0;

  tri_phase_pwm u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_high(act_high), .trip_n(trip_n), .gate_o(gate_o), .sync_o(sync_o), .trip_o(trip_o)
  );

  always #2 clk = ~clk;

  task automatic chk_eq(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // monitor: counts active clocks per pin between sync rises, compares with queue
  always @(negedge clk) begin
    if (!rst_n) begin
      armed = 1'b0;
      sync_prev = 1'b0;
      for (int i = 0; i < 7; i++) cnt[i] = 0;
    end else begin
      if (sync_o && !sync_prev) begin
        if (armed && q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          for (int i = 0; i < 7; i++) begin
            if (it.m[i]) begin
              checks++;
              if (cnt[i] != int'(it.v[i])) begin
                failures++;
                $display("FAIL R%0d pin %0d actual=%0d expected=%0d", it.r, i, cnt[i], it.v[i]);
              end
            end
          end
        end
        armed = (q.size() > 0);
        for (int i = 0; i < 7; i++) cnt[i] = 0;
      end
      sync_prev = sync_o;
      for (int i = 0; i < 6; i++) if (gate_o[i]) cnt[i]++;
      if (sync_o) cnt[6]++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input bit dbl, input bit chop, input logic [5:0] en);
    wr(3'd6, {8'h00, en, chop, dbl});
  endtask

  task automatic settle();
    repeat (3) @(posedge sync_o);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  // timing law restated from the requirements
  function automatic int hi_clks(int d, int h, int dt, int mp);
    int ds = (d > h) ? h : d;
    if (ds < mp) ds = 0;
    else if (h - ds < mp) ds = h;
    if (ds == 0) return 0;
    if (ds == h) return 2 * h;
    return (2 * ds > 2 * dt) ? 2 * ds - 2 * dt : 0;
  endfunction

  function automatic int lo_clks(int d, int h, int dt, int mp);
    int ds = (d > h) ? h : d;
    if (ds < mp) ds = 0;
    else if (h - ds < mp) ds = h;
    if (ds == h) return 0;
    if (ds == 0) return 2 * h;
    return (2 * (h - ds) > 2 * dt) ? 2 * (h - ds) - 2 * dt : 0;
  endfunction

  task automatic expect_cfg(input int h, input int da, input int db, input int dc,
                            input int dt, input int mp, input logic [5:0] en,
                            input bit pol, input int sw, input int req);
    item_t it;
    int d[3];
    d[0] = da; d[1] = db; d[2] = dc;
    for (int p = 0; p < 3; p++) begin
      int a_hi = en[2*p]   ? hi_clks(d[p], h, dt, mp) : 0;
      int a_lo = en[2*p+1] ? lo_clks(d[p], h, dt, mp) : 0;
      it.v[2*p]   = 16'(pol ? a_hi : 2 * h - a_hi);
      it.v[2*p+1] = 16'(pol ? a_lo : 2 * h - a_lo);
    end
    it.v[6] = 16'(sw + 1);
    it.m = 7'h7F;
    it.r = 8'(req);
    q.push_back(it);
    drain();
  endtask

  initial begin
    item_t it;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_eq(gate_o, 0, "R1 gates");
    chk_eq(sync_o, 0, "R1 sync");
    chk_eq(trip_o, 0, "R1 trip");
    rst_n = 1'b1;

    // R2 and R7: centred pulses, saturation of C, sync width 10
    wr(3'd7, {8'd0, 8'd9});
    wr(3'd0, 16'd40); wr(3'd1, 16'd10); wr(3'd2, 16'd25); wr(3'd3, 16'd60);
    settle();
    expect_cfg(40, 10, 25, 60, 0, 0, 6'h3F, 1, 9, 2);

    // R3: dead time 3 (6 clocks)
    wr(3'd4, 16'd3);
    settle();
    expect_cfg(40, 10, 25, 60, 3, 0, 6'h3F, 1, 9, 3);

    // R4: minimum pulse 12 deletes A, forces B full on
    wr(3'd5, 16'd12); wr(3'd2, 16'd30);
    settle();
    expect_cfg(40, 10, 30, 60, 3, 12, 6'h3F, 1, 9, 4);
    wr(3'd5, 16'd0); wr(3'd2, 16'd25);

    // R8: AH and BL disabled
    ctl(0, 0, 6'b110110);
    settle();
    expect_cfg(40, 10, 25, 60, 3, 0, 6'b110110, 1, 9, 8);

    // R9: inverted polarity
    ctl(0, 0, 6'h3F);
    act_high = 1'b0;
    settle();
    expect_cfg(40, 10, 25, 60, 3, 0, 6'h3F, 0, 9, 9);
    act_high = 1'b1;

    // R10: chopping with carrier period 4 on full-on AL and CH
    wr(3'd1, 16'd0); wr(3'd4, 16'd0);
    wr(3'd7, {8'd1, 8'd9});
    ctl(0, 1, 6'h3F);
    settle();
    it.v = '0; it.v[1] = 16'd40; it.v[4] = 16'd40; it.v[6] = 16'd10;
    it.m = 7'b1110011; it.r = 8'd10;
    q.push_back(it);
    drain();
    ctl(0, 0, 6'h3F);
    wr(3'd7, {8'd0, 8'd9});

    // R6: double update, duty written in first half reaches second half
    wr(3'd2, 16'd0); wr(3'd3, 16'd0);
    ctl(1, 0, 6'h3F);
    settle();
    it.v = '0; it.v[0] = 16'd10; it.v[1] = 16'd70; it.m = 7'b0000011; it.r = 8'd6;
    q.push_back(it);
    wait (armed);
    repeat (8) @(negedge clk);
    wr(3'd1, 16'd10);
    drain();

    // R5: single update, same write leaves the current period untouched
    ctl(0, 0, 6'h3F);
    wr(3'd1, 16'd0);
    settle();
    it.v = '0; it.v[0] = 16'd0; it.v[1] = 16'd80; it.m = 7'b0000011; it.r = 8'd5;
    q.push_back(it);
    wait (armed);
    repeat (8) @(negedge clk);
    wr(3'd1, 16'd10);
    drain();

    // R11: asynchronous trip, latch, clear rules
    wr(3'd1, 16'd20); wr(3'd2, 16'd25); wr(3'd3, 16'd60);
    settle();
    @(negedge clk);
    #0.5 trip_n = 1'b0;
    #0.5 chk_eq(gate_o, 0, "R11 async shutdown");
    wr(3'd6, 16'h80FC);
    chk_eq(trip_o, 1, "R11 clear ignored while low");
    repeat (3) @(negedge clk);
    trip_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_eq(trip_o, 1, "R11 latched");
    chk_eq(gate_o, 0, "R11 held inactive");
    wr(3'd6, 16'h80FC);
    chk_eq(trip_o, 0, "R11 cleared");
    settle();
    expect_cfg(40, 20, 25, 60, 0, 0, 6'h3F, 1, 9, 11);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule